// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This engine takes a single 64-bit send command and turns it into a 32-bit write into the register space of another core. The command names the destination core and carries a 32-bit payload. It also carries a four-bit preserve mask with one bit per byte lane. A set mask bit keeps that byte of the word already at the target. When any mask bit is set, the engine first reads the target word, merges it with the payload and writes the result back. When the mask is zero, it writes the payload directly and issues no read.

Two command forms select the target address. The mailbox form picks one of eight mailbox words at a fixed offset above a configurable mailbox base. The arbitrary form takes any 16-bit address straight from the command. All target traffic goes out on a simple valid/ready master port that carries the destination core number.

A command aimed at a core that does not exist gets a decode-error response and produces no target access. A command that is not a 64-bit access gets the same response. While one command is in flight, the engine reports busy and refuses further commands.

Top module: `mbox_rmw_writer`

## Requirements
- R1: After reset, `busy`, `m_valid` and `rsp_valid` are low and `cmd_ready` is high.
- R2: If command bits [30:27] are all zero, the engine issues no read and performs exactly one write of the full payload (command bits [63:32]).
- R3: If any of command bits [30:27] is set, the engine issues one read of the target word, then one write of `(old & M) | (payload & ~M)`. Here M sets byte i to 0xFF when command bit 27+i is set.
- R4: When `cmd_kind` is 0 (mailbox form), the target address is `MBOX_BASE + 0x20 + (command & 0x1C)`.
- R5: When `cmd_kind` is 1 (arbitrary form), the target address is command bits [15:0].
- R6: The destination core (command bits [25:16]) is driven on `m_core` for both the read and the write.
- R7: A core number of `NUM_CORES` or above gives `rsp_valid` with `rsp_err`=1 one cycle after acceptance, and no master access.
- R8: A command with `cmd_wide`=0 (not a 64-bit access) gives `rsp_valid` with `rsp_err`=1 one cycle after acceptance, and no master access.
- R9: `busy` is high from the cycle after acceptance until the write handshake. `cmd_ready` is low while busy, and a command offered then is not taken until the engine is idle.
- R10: While `m_valid` is high and `m_ready` is low, `m_write`, `m_addr`, `m_core` and `m_wdata` hold steady.
- R11: The cycle after the write handshake, `rsp_valid` pulses for one cycle with `rsp_err`=0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_wide | input | 1 | Access is 64 bits wide |
| cmd_kind | input | 1 | 0 mailbox form, 1 arbitrary form |
| cmd_data | input | 64 | Send command |
| busy | output | 1 | Command in flight |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Decode error with rsp_valid |
| m_valid | output | 1 | Target request valid |
| m_ready | input | 1 | Target request accepted |
| m_write | output | 1 | 1 write, 0 read |
| m_core | output | 10 | Destination core number |
| m_addr | output | 16 | Target byte address |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with a read handshake |

## Verification
A wrong merge mask or a wrongly latched payload appears as a wrong `m_wdata` at the write handshake, one transfer after the read. A read issued or skipped in error changes the number of read handshakes for that command. A state machine stuck in a non-idle state leaves `busy` high and `cmd_ready` low, and no `rsp_valid` follows. A missing decode check appears as a master access within one cycle where an error response was due. Every one of these shows within a few cycles of the command's acceptance.

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer #(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [15:0] MBOX_BASE = 16'h0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_wide,
  input  logic        cmd_kind,
  input  logic [63:0] cmd_data,
  output logic        busy,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic        m_valid,
  input  logic        m_ready,
  output logic        m_write,
  output logic [9:0]  m_core,
  output logic [15:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic [31:0] m_rdata
);
  typedef enum logic [1:0] {IDLE, READ, WRITE} state_t;
  state_t state;

  logic [31:0] keep_q;
  logic [31:0] keep_m;
  logic [9:0]  dst;
  logic        core_ok, take;
  logic [15:0] tgt;

  assign dst     = cmd_data[25:16];
  assign core_ok = {22'd0, dst} < NUM_CORES;
  assign tgt     = cmd_kind ? cmd_data[15:0]
                            : MBOX_BASE + 16'h0020 + {11'd0, cmd_data[4:2], 2'b00};

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_lane
      assign keep_m[8*g +: 8] = {8{cmd_data[27+g]}};
    end
  endgenerate

  assign busy      = state != IDLE;
  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;
  assign m_valid   = busy;
  assign m_write   = state == WRITE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      keep_q    <= '0;
      m_core    <= '0;
      m_addr    <= '0;
      m_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        IDLE: if (take) begin
          if (!cmd_wide || !core_ok) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
          end else begin
            m_core  <= dst;
            m_addr  <= tgt;
            m_wdata <= cmd_data[63:32];
            keep_q  <= keep_m;
            state   <= (cmd_data[30:27] != 4'd0) ? READ : WRITE;
          end
        end
        READ: if (m_ready) begin
          m_wdata <= (m_rdata & keep_q) | (m_wdata & ~keep_q);
          state   <= WRITE;
        end
        WRITE: if (m_ready) begin
          rsp_valid <= 1'b1;
          state     <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_rmw_checker.sv
module mbox_rmw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        busy,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic [9:0]  m_core,
  input logic [15:0] m_addr,
  input logic [31:0] m_wdata
);
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_write) && $stable(m_addr)
                            && $stable(m_core) && $stable(m_wdata));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_write |=> m_valid && m_write && $stable(m_addr) && $stable(m_core));

  p_err_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !m_valid && !$past(m_valid));

  p_done_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_write |=> rsp_valid && !rsp_err && !busy);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !cmd_ready);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !m_valid);
endmodule

bind mbox_rmw_writer mbox_rmw_checker chk (.*);

// File: tb/tb_mbox_rmw_writer.sv
module tb_mbox_rmw_writer;
  localparam logic [15:0] BASE = 16'h0800;
  localparam int NC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wide = 1'b1, cmd_kind = 1'b0;
  logic [63:0] cmd_data = '0;
  logic cmd_ready, busy, rsp_valid, rsp_err, m_valid, m_ready, m_write;
  logic [9:0] m_core;
  logic [15:0] m_addr;
  logic [31:0] m_wdata, m_rdata;

  int checks = 0, fails = 0;
  int wait_cfg = 0, wcnt = 0;
  int rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0, err_cnt = 0, busy_cnt = 0;
  logic [9:0] wr_core, rd_core;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  always #2 clk = ~clk;

  mbox_rmw_writer #(.NUM_CORES(NC), .MBOX_BASE(BASE)) dut (.*);

  function automatic logic [31:0] rfn(input logic [9:0] c, input logic [15:0] a);
    return {a, 6'd0, c} ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] p, input logic [3:0] m,
                                     input logic [9:0] c, input logic [15:0] lo);
    return {p, 1'b0, m, 1'b0, c, lo};
  endfunction

  assign m_ready = m_valid && (wcnt >= wait_cfg);
  assign m_rdata = rfn(m_core, m_addr);

  always @(posedge clk) begin
    if (m_valid && !m_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (m_valid && m_ready) begin
      if (m_write) begin
        wr_cnt <= wr_cnt + 1; wr_core <= m_core; wr_addr <= m_addr; wr_data <= m_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1; rd_core <= m_core;
      end
    end
    if (rsp_valid) begin rsp_cnt <= rsp_cnt + 1; if (rsp_err) err_cnt <= err_cnt + 1; end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind, command, wait}
  localparam logic [66:0] VEC [7] = '{
    {1'b0, mk(32'hDEADBEEF, 4'b0000, 10'd1, 16'h0004), 2'd0},
    {1'b0, mk(32'h11223344, 4'b0101, 10'd2, 16'h001C), 2'd1},
    {1'b1, mk(32'hCAFEF00D, 4'b1111, 10'd3, 16'h1234), 2'd2},
    {1'b1, mk(32'h55667788, 4'b1000, 10'd0, 16'hFFFC), 2'd0},
    {1'b0, mk(32'h0BADC0DE, 4'b0010, 10'd0, 16'h00FF), 2'd3},
    {1'b0, mk(32'h12345678, 4'b0001, 10'd4, 16'h0008), 2'd0},
    {1'b1, mk(32'h87654321, 4'b0000, 10'h3FF, 16'h0100), 2'd0}
  };

  task automatic issue(input logic wide, input logic kind, input logic [63:0] d);
    @(negedge clk);
    cmd_wide = wide; cmd_kind = kind; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int base);
    for (int n = 0; n < 60 && rsp_cnt == base; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 m_valid", m_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0); chk("R1 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      logic k; logic [63:0] c; logic [31:0] bm, pay, exp; logic [15:0] ea;
      int r0, w0, s0, e0;
      k = VEC[i][66]; c = VEC[i][65:2]; wait_cfg = int'(VEC[i][1:0]);
      r0 = rd_cnt; w0 = wr_cnt; s0 = rsp_cnt; e0 = err_cnt;
      for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{c[27+b]}};
      pay = c[63:32];
      ea = k ? c[15:0] : BASE + 16'h20 + (c[15:0] & 16'h1C);
      exp = (c[30:27] != 0) ? ((rfn(c[25:16], ea) & bm) | (pay & ~bm)) : pay;
      issue(1'b1, k, c);
      wait_rsp(s0);
      chk("R11 rsp count", rsp_cnt - s0, 1);
      if (c[25:16] >= NC) begin
        chk("R7 err", err_cnt - e0, 1);
        chk("R7 no access", (rd_cnt - r0) + (wr_cnt - w0), 0);
      end else begin
        chk("R11 no err", err_cnt - e0, 0);
        chk(c[30:27] != 0 ? "R3 reads" : "R2 reads", rd_cnt - r0, c[30:27] != 0);
        chk("R2 writes", wr_cnt - w0, 1);
        chk(k ? "R5 addr" : "R4 addr", wr_addr, ea);
        chk("R6 core", wr_core, c[25:16]);
        if (c[30:27] != 0) chk("R6 read core", rd_core, c[25:16]);
        chk(c[30:27] != 0 ? "R3 data" : "R2 data", wr_data, exp);
        chk("R11 idle", busy, 0);
      end
    end

    begin
      int r0, w0, s0, e0;
      r0 = rd_cnt; w0 = wr_cnt; s0 = rsp_cnt; e0 = err_cnt;
      issue(1'b0, 1'b1, mk(32'h1, 4'b0000, 10'd1, 16'h0040));
      wait_rsp(s0);
      chk("R8 err", err_cnt - e0, 1);
      chk("R8 no access", (rd_cnt - r0) + (wr_cnt - w0), 0);
    end

    begin
      int w0, s0, r0;
      wait_cfg = 3; w0 = wr_cnt; s0 = rsp_cnt; r0 = rd_cnt;
      issue(1'b1, 1'b0, mk(32'hA0A0A0A0, 4'b0100, 10'd2, 16'h0010));
      chk("R9 busy", busy, 1);
      chk("R9 stall", cmd_ready, 0);
      cmd_data = mk(32'hB1B1B1B1, 4'b0000, 10'd3, 16'h0000); cmd_kind = 1'b0; cmd_valid = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 held", cmd_ready, 0);
      chk("R10 no early write", wr_cnt - w0, 0);
      while (!cmd_ready) @(negedge clk);
      chk("R9 first done", wr_data, (rfn(10'd2, BASE + 16'h30) & 32'h00FF0000) | (32'hA0A0A0A0 & 32'hFF00FFFF));
      @(negedge clk); cmd_valid = 1'b0;
      wait_rsp(s0 + 1);
      chk("R9 second taken", wr_data, 32'hB1B1B1B1);
      chk("R9 reads", rd_cnt - r0, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule